// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home node of a directory-based coherence scheme for a few memory blocks shared by three processors. For each block it keeps a coherence state (uncached, shared or exclusive) and a presence vector with one bit per processor. It also owns the local memory word of each block. Cache controllers send it read misses, write misses and data write-backs. The block answers each miss with a data reply that grants the line as shared or exclusive. It sends invalidate, switch-to-shared or take-away commands to the other caches when the directory entry calls for them.

When a miss hits a block that one cache holds exclusively, the controller commands that owner to give the line up. It then stalls the request port until the owner's data arrives on a dedicated recall port. That data updates memory, is forwarded to the requester and completes the directory transition. The internal state encoding is 2'b00 uncached, 2'b01 shared and 2'b10 exclusive. Requests, replies and commands use separate ports, so an invalidate and the matching exclusive reply can leave in the same cycle.

Top module: `cohDirTop`

## Requirements
- R1: After reset, every entry is uncached with an empty vector, memory word i holds i XOR 8'hA5, reqReady is high, and rspValid and cmdValid are low.
- R2: A read miss (reqKind 0) to an uncached block gets a reply in the next cycle with grant 0 (shared), rspDest equal to the requester and the memory word as data. The entry becomes shared with only the requester's bit set (mask bit i stands for processor i).
- R3: A read miss to a shared block is answered the same way from memory and issues no command. The requester's bit is added to the existing vector, and the state stays shared.
- R4: A write miss (reqKind 1) to a shared block replies in the next cycle with grant 1 (exclusive) and memory data. In that same cycle, a single invalidate command (cmdKind 0) goes out whose mask is the vector without the writer's bit, unless that mask is empty. The entry becomes exclusive with only the writer's bit.
- R5: A write miss to an uncached block gets an exclusive reply from memory with no command, and the entry becomes exclusive with only the writer's bit.
- R6: A read miss to an exclusive block issues, in the next cycle, a switch-to-shared command (cmdKind 1) whose mask is the owner's one-hot bit, with no reply. reqReady then stays low and further requests are held off until recallValid. One cycle after recallValid, memory holds recallData, a shared reply carries recallData, reqReady is high again, and the entry is shared with both the owner's and the requester's bits.
- R7: A write miss to an exclusive block uses the same recall, but with a take-away command (cmdKind 2). The reply after the owner's data is exclusive and carries that data, memory is updated, and the entry stays exclusive with only the writer's bit.
- R8: A write-back (reqKind 2) from the processor whose bit is the only one set on an exclusive entry writes reqData to memory and makes the entry uncached with an empty vector. It produces neither reply nor command.
- R9: A write-back from any other processor, or to a block that is not exclusive, is ignored: memory and the entry do not change, and no reply or command is produced.
- R10: A request with reqKind 3, or with reqSrc of 3 or more, is ignored with no reply, no command and no change to any entry or memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can accept a request (low during a recall) |
| reqKind | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 none |
| reqSrc | input | 2 | Requesting processor |
| reqAddr | input | 2 | Block index |
| reqData | input | 8 | Write-back data |
| recallValid | input | 1 | Owner's data for a pending recall |
| recallData | input | 8 | Data returned by the owner |
| rspValid | output | 1 | Reply strobe |
| rspDest | output | 2 | Processor receiving the reply |
| rspGrant | output | 1 | 0 shared, 1 exclusive |
| rspData | output | 8 | Block data word |
| cmdValid | output | 1 | Command strobe |
| cmdKind | output | 2 | 0 invalidate, 1 switch to shared, 2 take away |
| cmdMask | output | 3 | Target caches, one bit per processor |
| cmdAddr | output | 2 | Block the command refers to |

## Verification
The assertions assume that recallValid is raised only while a recall is outstanding, meaning after a switch-to-shared or take-away command and before the reply. They also assume that the owner returns its data exactly once. The bench keeps to this by driving recallValid from the recall step of its request task only, with a varying delay of zero to two cycles. During those wait cycles it presents a conflicting write-back, which must stay unaccepted. A sweep covers every request kind, source code and block index, so each directory state meets every request from every processor, owner included.

// File: rtl/cohDirPkg.sv
package cohDirPkg;

  typedef enum logic [1:0] {
    DIR_U = 2'b00,
    DIR_S = 2'b01,
    DIR_E = 2'b10
  } dirState_e;

  typedef enum logic [1:0] {
    REQ_RD  = 2'd0,
    REQ_WR  = 2'd1,
    REQ_WB  = 2'd2,
    REQ_NOP = 2'd3
  } reqKind_e;

  typedef enum logic [1:0] {
    CMD_INV  = 2'd0,
    CMD_SHR  = 2'd1,
    CMD_TAKE = 2'd2
  } cmdKind_e;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic      dirWe;
    dirState_e newState;
    logic      memWe;
    logic      memFromRecall;
    logic      rspLoad;
    logic      rspGrant;
    logic      rspFromRecall;
    logic      cmdLoad;
    cmdKind_e  cmdKind;
  } dirStrobe_t;

endpackage

// File: rtl/cohDirCtrl.sv
module cohDirCtrl
  import cohDirPkg::*;
#(
  parameter int NUM_PROC = 3,
  parameter int ADDR_W   = 2,
  parameter int SRC_W    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [1:0]          reqKind,
  input  logic [SRC_W-1:0]    reqSrc,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                recallValid,
  input  dirState_e           curState,
  input  logic [NUM_PROC-1:0] curVec,
  output logic                reqReady,
  output logic [ADDR_W-1:0]   curAddr,
  output logic [SRC_W-1:0]    rspDestNxt,
  output logic [NUM_PROC-1:0] newVec,
  output logic [NUM_PROC-1:0] cmdMaskNxt,
  output dirStrobe_t          stb
);

  typedef enum logic {C_IDLE, C_RECALL} ctrlSt_e;

  ctrlSt_e             ctrlSt;
  reqKind_e            holdKind;
  logic [SRC_W-1:0]    holdSrc;
  logic [ADDR_W-1:0]   holdAddr;
  logic                goRecall;
  logic                endRecall;
  logic                srcOk;
  logic [NUM_PROC-1:0] srcBit;
  logic [NUM_PROC-1:0] holdBit;
  logic [NUM_PROC-1:0] otherSharers;
  reqKind_e            kindIn;

  assign kindIn       = reqKind_e'(reqKind);
  assign srcOk        = 32'(reqSrc) < NUM_PROC;
  assign srcBit       = NUM_PROC'(1) << reqSrc;
  assign holdBit      = NUM_PROC'(1) << holdSrc;
  assign otherSharers = curVec & ~srcBit;
  assign reqReady     = (ctrlSt == C_IDLE);
  assign curAddr      = (ctrlSt == C_IDLE) ? reqAddr : holdAddr;
  assign rspDestNxt   = (ctrlSt == C_IDLE) ? reqSrc  : holdSrc;

  always_comb begin
    stb        = '0;
    newVec     = '0;
    cmdMaskNxt = '0;
    goRecall   = 1'b0;
    endRecall  = 1'b0;
    if (ctrlSt == C_IDLE) begin
      if (reqValid && srcOk) begin
        case (kindIn)
          REQ_RD: begin
            if (curState == DIR_E) begin
              stb.cmdLoad = 1'b1;
              stb.cmdKind = CMD_SHR;
              cmdMaskNxt  = curVec;
              goRecall    = 1'b1;
            end else begin
              stb.dirWe    = 1'b1;
              stb.newState = DIR_S;
              newVec       = (curState == DIR_S) ? (curVec | srcBit) : srcBit;
              stb.rspLoad  = 1'b1;
              stb.rspGrant = 1'b0;
            end
          end
          REQ_WR: begin
            if (curState == DIR_E) begin
              stb.cmdLoad = 1'b1;
              stb.cmdKind = CMD_TAKE;
              cmdMaskNxt  = curVec;
              goRecall    = 1'b1;
            end else begin
              stb.dirWe    = 1'b1;
              stb.newState = DIR_E;
              newVec       = srcBit;
              stb.rspLoad  = 1'b1;
              stb.rspGrant = 1'b1;
              if (curState == DIR_S && otherSharers != '0) begin
                stb.cmdLoad = 1'b1;
                stb.cmdKind = CMD_INV;
                cmdMaskNxt  = otherSharers;
              end
            end
          end
          REQ_WB: begin
            if (curState == DIR_E && curVec == srcBit) begin
              stb.memWe         = 1'b1;
              stb.memFromRecall = 1'b0;
              stb.dirWe         = 1'b1;
              stb.newState      = DIR_U;
              newVec            = '0;
            end
          end
          default: ;
        endcase
      end
    end else if (recallValid) begin
      endRecall         = 1'b1;
      stb.memWe         = 1'b1;
      stb.memFromRecall = 1'b1;
      stb.rspLoad       = 1'b1;
      stb.rspFromRecall = 1'b1;
      stb.dirWe         = 1'b1;
      if (holdKind == REQ_RD) begin
        stb.newState = DIR_S;
        newVec       = curVec | holdBit;
        stb.rspGrant = 1'b0;
      end else begin
        stb.newState = DIR_E;
        newVec       = holdBit;
        stb.rspGrant = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlSt   <= C_IDLE;
      holdKind <= REQ_RD;
      holdSrc  <= '0;
      holdAddr <= '0;
    end else if (goRecall) begin
      ctrlSt   <= C_RECALL;
      holdKind <= kindIn;
      holdSrc  <= reqSrc;
      holdAddr <= reqAddr;
    end else if (endRecall) begin
      ctrlSt <= C_IDLE;
    end
  end

endmodule

// File: rtl/cohDirPath.sv
module cohDirPath
  import cohDirPkg::*;
#(
  parameter int NUM_PROC = 3,
  parameter int NUM_BLK  = 4,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int SRC_W    = 2,
  parameter logic [DATA_W-1:0] RST_PAT = 'hA5
) (
  input  logic                clk,
  input  logic                rstN,
  input  dirStrobe_t          stb,
  input  logic [ADDR_W-1:0]   curAddr,
  input  logic [SRC_W-1:0]    rspDestNxt,
  input  logic [NUM_PROC-1:0] newVec,
  input  logic [NUM_PROC-1:0] cmdMaskNxt,
  input  logic [DATA_W-1:0]   reqData,
  input  logic [DATA_W-1:0]   recallData,
  output dirState_e           curState,
  output logic [NUM_PROC-1:0] curVec,
  output logic                rspValid,
  output logic [SRC_W-1:0]    rspDest,
  output logic                rspGrant,
  output logic [DATA_W-1:0]   rspData,
  output logic                cmdValid,
  output logic [1:0]          cmdKind,
  output logic [NUM_PROC-1:0] cmdMask,
  output logic [ADDR_W-1:0]   cmdAddr
);

  dirState_e           stRd  [NUM_BLK];
  logic [NUM_PROC-1:0] vecRd [NUM_BLK];
  logic [DATA_W-1:0]   memRd [NUM_BLK];
  logic [DATA_W-1:0]   memWdata;
  logic [DATA_W-1:0]   memCur;

  assign memWdata = stb.memFromRecall ? recallData : reqData;

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    dirState_e           stQ;
    logic [NUM_PROC-1:0] vecQ;
    logic [DATA_W-1:0]   memQ;
    logic                hit;

    assign hit = (32'(curAddr) == g);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stQ  <= DIR_U;
        vecQ <= '0;
        memQ <= DATA_W'(g) ^ RST_PAT;
      end else if (hit) begin
        if (stb.dirWe) begin
          stQ  <= stb.newState;
          vecQ <= newVec;
        end
        if (stb.memWe) memQ <= memWdata;
      end
    end

    assign stRd[g]  = stQ;
    assign vecRd[g] = vecQ;
    assign memRd[g] = memQ;
  end

  assign curState = stRd[curAddr];
  assign curVec   = vecRd[curAddr];
  assign memCur   = memRd[curAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspDest  <= '0;
      rspGrant <= 1'b0;
      rspData  <= '0;
      cmdValid <= 1'b0;
      cmdKind  <= '0;
      cmdMask  <= '0;
      cmdAddr  <= '0;
    end else begin
      rspValid <= stb.rspLoad;
      cmdValid <= stb.cmdLoad;
      if (stb.rspLoad) begin
        rspDest  <= rspDestNxt;
        rspGrant <= stb.rspGrant;
        rspData  <= stb.rspFromRecall ? recallData : memCur;
      end
      if (stb.cmdLoad) begin
        cmdKind <= stb.cmdKind;
        cmdMask <= cmdMaskNxt;
        cmdAddr <= curAddr;
      end
    end
  end

endmodule

// File: rtl/cohDirTop.sv
module cohDirTop
  import cohDirPkg::*;
#(
  parameter int NUM_PROC = 3,
  parameter int NUM_BLK  = 4,
  parameter int DATA_W   = 8,
  parameter int RST_PAT  = 'hA5,
  localparam int ADDR_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
  localparam int SRC_W   = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [1:0]          reqKind,
  input  logic [SRC_W-1:0]    reqSrc,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData,
  input  logic                recallValid,
  input  logic [DATA_W-1:0]   recallData,
  output logic                rspValid,
  output logic [SRC_W-1:0]    rspDest,
  output logic                rspGrant,
  output logic [DATA_W-1:0]   rspData,
  output logic                cmdValid,
  output logic [1:0]          cmdKind,
  output logic [NUM_PROC-1:0] cmdMask,
  output logic [ADDR_W-1:0]   cmdAddr
);

  dirStrobe_t          stb;
  dirState_e           curState;
  logic [NUM_PROC-1:0] curVec;
  logic [NUM_PROC-1:0] newVec;
  logic [NUM_PROC-1:0] cmdMaskNxt;
  logic [ADDR_W-1:0]   curAddr;
  logic [SRC_W-1:0]    rspDestNxt;

  cohDirCtrl #(
    .NUM_PROC(NUM_PROC), .ADDR_W(ADDR_W), .SRC_W(SRC_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqSrc(reqSrc), .reqAddr(reqAddr), .recallValid(recallValid),
    .curState(curState), .curVec(curVec), .reqReady(reqReady),
    .curAddr(curAddr), .rspDestNxt(rspDestNxt), .newVec(newVec),
    .cmdMaskNxt(cmdMaskNxt), .stb(stb)
  );

  cohDirPath #(
    .NUM_PROC(NUM_PROC), .NUM_BLK(NUM_BLK), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .SRC_W(SRC_W), .RST_PAT(DATA_W'(RST_PAT))
  ) path_i (
    .clk(clk), .rstN(rstN), .stb(stb), .curAddr(curAddr),
    .rspDestNxt(rspDestNxt), .newVec(newVec), .cmdMaskNxt(cmdMaskNxt),
    .reqData(reqData), .recallData(recallData), .curState(curState),
    .curVec(curVec), .rspValid(rspValid), .rspDest(rspDest),
    .rspGrant(rspGrant), .rspData(rspData), .cmdValid(cmdValid),
    .cmdKind(cmdKind), .cmdMask(cmdMask), .cmdAddr(cmdAddr)
  );

endmodule

// File: rtl/cohDirChk.sv
module cohDirChk #(
  parameter int NUM_PROC = 3,
  parameter int DATA_W   = 8,
  parameter int SRC_W    = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqReady,
  input logic [1:0]          reqKind,
  input logic                recallValid,
  input logic [DATA_W-1:0]   recallData,
  input logic                rspValid,
  input logic [SRC_W-1:0]    rspDest,
  input logic                rspGrant,
  input logic [DATA_W-1:0]   rspData,
  input logic                cmdValid,
  input logic [1:0]          cmdKind,
  input logic [NUM_PROC-1:0] cmdMask
);

  // R6: a recall command leaves the request port stalled
  p_recall_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdKind != 2'd0 |-> !reqReady);

  // R6: a recall targets exactly one owner
  p_recall_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdKind != 2'd0 |-> $countones(cmdMask) == 1);

  // R7: the owner's data is forwarded in the next reply and the port reopens
  p_recall_reply_r7: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady && recallValid |=> rspValid && reqReady && rspData == $past(recallData));

  // R4: invalidate travels with an exclusive reply and spares the writer
  p_inval_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdKind == 2'd0 |->
      rspValid && rspGrant && (cmdMask & (NUM_PROC'(1) << rspDest)) == '0);

  // R8: write-backs never produce a reply or command
  p_wb_silent_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && reqKind == 2'd2 |=> !rspValid && !cmdValid);

  // R10: the unused request code is silent
  p_nop_silent_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && reqKind == 2'd3 |=> !rspValid && !cmdValid);

endmodule

bind cohDirTop cohDirChk #(
  .NUM_PROC(NUM_PROC), .DATA_W(DATA_W), .SRC_W(SRC_W)
) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqKind(reqKind), .recallValid(recallValid), .recallData(recallData),
  .rspValid(rspValid), .rspDest(rspDest), .rspGrant(rspGrant),
  .rspData(rspData), .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdMask(cmdMask)
);

// File: tb/cohDirTop_tb_top.sv
module cohDirTop_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NBLK = 4;
  localparam int NPROC = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [1:0] reqKind = 2'd0;
  logic [1:0] reqSrc = 2'd0;
  logic [1:0] reqAddr = 2'd0;
  logic [7:0] reqData = 8'd0;
  logic       recallValid = 1'b0;
  logic [7:0] recallData = 8'd0;
  logic       rspValid;
  logic [1:0] rspDest;
  logic       rspGrant;
  logic [7:0] rspData;
  logic       cmdValid;
  logic [1:0] cmdKind;
  logic [2:0] cmdMask;
  logic [1:0] cmdAddr;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // bench model: 0 uncached, 1 shared, 2 exclusive
  int         mSt  [NBLK];
  logic [2:0] mVec [NBLK];
  logic [7:0] mMem [NBLK];

  always #(CLK_PERIOD / 2) clk = ~clk;

  cohDirTop dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqSrc(reqSrc), .reqAddr(reqAddr), .reqData(reqData),
    .recallValid(recallValid), .recallData(recallData), .rspValid(rspValid),
    .rspDest(rspDest), .rspGrant(rspGrant), .rspData(rspData),
    .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdMask(cmdMask), .cmdAddr(cmdAddr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  // One request; all expectations come from the model before it is updated.
  task automatic doReq(input int kind, input int src, input int addr,
                       input logic [7:0] wd, input int waitCyc, input logic [7:0] rd);
    logic [2:0] sBit;
    logic [2:0] others;
    string tag;
    bit recall;
    sBit = 3'b001 << src;
    others = mVec[addr] & ~sBit;
    recall = (src < NPROC) && (kind < 2) && (mSt[addr] == 2);
    chk(reqReady == 1'b1, "R6", "ready before request", reqReady, 1);
    reqValid = 1'b1; reqKind = 2'(kind); reqSrc = 2'(src);
    reqAddr = 2'(addr); reqData = wd;
    @(negedge clk);
    reqValid = 1'b0;
    if (src >= NPROC || kind == 3) begin
      chk(!rspValid && !cmdValid, "R10", "ignored request silent",
          {rspValid, cmdValid}, 0);
    end else if (kind == 2) begin
      if (mSt[addr] == 2 && mVec[addr] == sBit) begin
        chk(!rspValid && !cmdValid, "R8", "owner write-back silent",
            {rspValid, cmdValid}, 0);
        mMem[addr] = wd; mSt[addr] = 0; mVec[addr] = 3'b000;
      end else begin
        chk(!rspValid && !cmdValid, "R9", "stray write-back silent",
            {rspValid, cmdValid}, 0);
      end
    end else if (recall) begin
      tag = (kind == 0) ? "R6" : "R7";
      chk(cmdValid && cmdKind == ((kind == 0) ? 2'd1 : 2'd2), tag, "recall command kind",
          {cmdValid, cmdKind}, (kind == 0) ? 5 : 6);
      chk(cmdMask == mVec[addr] && cmdAddr == 2'(addr), tag, "recall target",
          {cmdAddr, cmdMask}, {addr[1:0], mVec[addr]});
      chk(!rspValid && !reqReady, tag, "stall without reply", {rspValid, reqReady}, 0);
      for (int w = 0; w < waitCyc; w++) begin
        // conflicting write-back offered while stalled must not be taken
        reqValid = 1'b1; reqKind = 2'd2; reqSrc = 2'((src + 1) % NPROC); reqData = 8'hEE;
        @(negedge clk);
        chk(!reqReady && !rspValid, "R6", "still stalled", {reqReady, rspValid}, 0);
      end
      reqValid = 1'b0;
      recallValid = 1'b1; recallData = rd;
      @(negedge clk);
      recallValid = 1'b0;
      chk(rspValid && rspDest == 2'(src) && rspData == rd, tag, "reply after recall",
          {rspValid, rspDest, rspData}, {1'b1, src[1:0], rd});
      chk(rspGrant == (kind == 1) && reqReady, tag, "grant and reopen",
          {rspGrant, reqReady}, {(kind == 1), 1'b1});
      mMem[addr] = rd;
      if (kind == 0) begin mSt[addr] = 1; mVec[addr] = mVec[addr] | sBit; end
      else begin mSt[addr] = 2; mVec[addr] = sBit; end
    end else begin
      if (kind == 0) tag = (mSt[addr] == 0) ? "R2" : "R3";
      else tag = (mSt[addr] == 0) ? "R5" : "R4";
      chk(rspValid && rspDest == 2'(src) && rspData == mMem[addr], tag, "memory reply",
          {rspValid, rspDest, rspData}, {1'b1, src[1:0], mMem[addr]});
      chk(rspGrant == (kind == 1), tag, "grant", rspGrant, (kind == 1));
      if (kind == 1 && mSt[addr] == 1 && others != 3'b000) begin
        chk(cmdValid && cmdKind == 2'd0 && cmdMask == others && cmdAddr == 2'(addr),
            "R4", "invalidate others", {cmdValid, cmdKind, cmdMask},
            {1'b1, 2'd0, others});
      end else begin
        chk(!cmdValid, tag, "no command", cmdValid, 0);
      end
      if (kind == 0) begin
        mVec[addr] = (mSt[addr] == 1) ? (mVec[addr] | sBit) : sBit; mSt[addr] = 1;
      end else begin
        mVec[addr] = sBit; mSt[addr] = 2;
      end
    end
  endtask

  initial begin
    for (int b = 0; b < NBLK; b++) begin
      mSt[b] = 0; mVec[b] = 3'b000; mMem[b] = 8'(b) ^ 8'hA5;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !rspValid && !cmdValid, "R1", "reset outputs",
        {reqReady, rspValid, cmdValid}, 4);
    // R1: reset contents read back through first read miss of each block
    for (int b = 0; b < NBLK; b++) begin
      chk(mMem[b] == (8'(b) ^ 8'hA5), "R1", "model seed", mMem[b], 8'(b) ^ 8'hA5);
      doReq(0, b % NPROC, b, 8'h00, 0, 8'h00);
    end
    // sweep over every kind, source code and block
    for (int i = 0; i < 2400; i++) begin
      doReq(i % 4, (i / 4) % 4, ((i / 16) + (i / 64)) % NBLK,
            8'(i) ^ 8'h3C, i % 3, 8'(i * 7 + 3));
    end
    finishRun();
  end

endmodule